// File: doc/BRIEF.md
# Banked Binary-Point CPU Interface Register File

This block is the software-visible register file of one processor's interrupt CPU interface. It stores the priority mask, two copies of the binary point setting (one for secure callers and one for non-secure callers), an aliased view of the non-secure binary point, and a set of active-priority words. Requests arrive on a plain single-cycle register port: an offset, a write strobe, write data and a flag that marks the access as non-secure. Read data is returned in the same cycle from the offset and the flag.

A build-time switch says whether the security split exists. When it does, the binary point offset is steered to the copy matching the caller's security state. The non-secure copy is also reachable through the alias offset, but only secure callers can see or change it there. Any value stored into the non-secure copy is raised to a configurable floor. When the split is absent, the binary point offset has one shared copy and the alias offset is dead. The port carries no data stream, so it has no valid/ready handshake and never stalls: each write completes at the next clock edge.

Top module: `prio_cpuif_regs`

## Requirements
- R1: After reset the priority mask, the secure binary point and every active-priority word read 0, and the non-secure binary point copy reads MIN_BP (the parameter, 0 to 4).
- R2: Offset 0x04 holds the priority mask. A write keeps bits [7:0] of the data, and a read returns them in bits [7:0] with all upper bits zero.
- R3: A secure access to offset 0x08 uses the secure copy. A write keeps bits [2:0] with no floor, and a read returns them in bits [2:0].
- R4: With security present, a non-secure access to offset 0x08 uses the non-secure copy, which is the storage behind offset 0x1C. Non-secure writes leave the secure copy unchanged.
- R5: Each update of the non-secure copy stores max(data[2:0], MIN_BP).
- R6: Offset 0x1C reads 0 when the access is non-secure or security is absent. Otherwise it returns the non-secure copy.
- R7: A write to offset 0x1C updates the non-secure copy (masked to 3 bits, with the R5 floor) only when security is present and the access is secure. Any other write to 0x1C changes nothing.
- R8: Offsets 0xD0, 0xD4, 0xD8 and 0xDC hold active-priority words 0 to 3, with index (offset − 0xD0)/4. Each stores and returns all 32 data bits.
- R9: Every other offset reads 0, and writes to it change no register.
- R10: Without security, offset 0x08 is one copy shared by secure and non-secure callers with no floor. Offset 0x1C reads 0 and ignores writes.
- R11: A write takes effect at the clock edge where the strobe is sampled. During that cycle, reading the same offset still returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_addr | input | ADDR_W (8) | Byte offset of the access |
| reg_ns | input | 1 | High for a non-secure access |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Combinational read data for reg_addr and reg_ns |

## Verification
The properties assume that the offset, the security flag, the strobe and the write data are settled before each rising edge, and that the strobe is a plain level that is never unknown after reset. They do not assume any alignment, because misaligned offsets must read zero. The bench changes every input only at the falling edge, holds each write for exactly one cycle, and drives the whole 8-bit offset space, including misaligned values, with both security states. A second instance with security absent receives the same accesses, so the unbanked variant is checked against the same traffic.

// File: rtl/prio_cpuif_pkg.sv
package prio_cpuif_pkg;
  localparam int OFF_MASK = 'h04;
  localparam int OFF_BP   = 'h08;
  localparam int OFF_ABP  = 'h1C;
  localparam int OFF_ACT0 = 'hD0;
  localparam int MASK_W   = 8;
  localparam int BP_W     = 3;

  typedef logic [BP_W-1:0] bp_t;

  function automatic bp_t bp_floor(input bp_t v, input bp_t lo);
    return (v < lo) ? lo : v;
  endfunction
endpackage

// File: rtl/prio_cpuif_decode.sv
module prio_cpuif_decode #(
  parameter int ADDR_W  = 8,
  parameter int NUM_ACT = 4
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               sel_mask,
  output logic               sel_bp,
  output logic               sel_abp,
  output logic [NUM_ACT-1:0] sel_act
);
  import prio_cpuif_pkg::*;

  assign sel_mask = (addr == ADDR_W'(OFF_MASK));
  assign sel_bp   = (addr == ADDR_W'(OFF_BP));
  assign sel_abp  = (addr == ADDR_W'(OFF_ABP));

  for (genvar gi = 0; gi < NUM_ACT; gi++) begin : g_act_dec
    assign sel_act[gi] = (addr == ADDR_W'(OFF_ACT0 + 4 * gi));
  end
endmodule

// File: rtl/prio_cpuif_bp_bank.sv
module prio_cpuif_bp_bank
  import prio_cpuif_pkg::*;
#(
  parameter bit          HAS_SEC = 1'b1,
  parameter int unsigned MIN_BP  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic ns,
  input  logic sel_bp,
  input  logic sel_abp,
  input  bp_t  wval,
  output bp_t  rd_bp,
  output bp_t  rd_abp,
  output bp_t  bp_sec_q,
  output bp_t  bp_ns_q
);
  localparam bp_t FLOOR = bp_t'(MIN_BP);

  logic ns_view;
  logic sec_view;
  logic wr_sec;

  assign ns_view  = HAS_SEC && ns;
  assign sec_view = HAS_SEC && !ns;
  assign wr_sec   = wr && sel_bp && !ns_view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bp_sec_q <= '0;
    else if (wr_sec) bp_sec_q <= wval;
  end

  if (HAS_SEC) begin : g_banked
    logic wr_ns;
    assign wr_ns = wr && ((sel_bp && ns_view) || (sel_abp && sec_view));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bp_ns_q <= FLOOR;
      else if (wr_ns) bp_ns_q <= bp_floor(wval, FLOOR);
    end
  end else begin : g_flat
    assign bp_ns_q = FLOOR;
  end

  assign rd_bp  = ns_view ? bp_ns_q : bp_sec_q;
  assign rd_abp = sec_view ? bp_ns_q : '0;
endmodule

// File: rtl/prio_cpuif_act_words.sv
module prio_cpuif_act_words #(
  parameter int DATA_W  = 32,
  parameter int NUM_ACT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [NUM_ACT-1:0] sel_act,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rd_act
);
  logic [DATA_W-1:0] act_q [NUM_ACT];

  for (genvar gi = 0; gi < NUM_ACT; gi++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  act_q[gi] <= '0;
      else if (wr && sel_act[gi])  act_q[gi] <= wdata;
    end
  end

  always_comb begin
    rd_act = '0;
    for (int i = 0; i < NUM_ACT; i++) begin
      if (sel_act[i]) rd_act = act_q[i];
    end
  end
endmodule

// File: rtl/prio_cpuif_regs.sv
module prio_cpuif_regs
  import prio_cpuif_pkg::*;
#(
  parameter bit          HAS_SEC = 1'b1,
  parameter int unsigned MIN_BP  = 2,
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 32,
  parameter int          NUM_ACT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_ns,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic               sel_mask;
  logic               sel_bp;
  logic               sel_abp;
  logic [NUM_ACT-1:0] sel_act;
  logic [MASK_W-1:0]  mask_q;
  bp_t                rd_bp;
  bp_t                rd_abp;
  bp_t                bp_sec_q;
  bp_t                bp_ns_q;
  logic [DATA_W-1:0]  rd_act;

  prio_cpuif_decode #(.ADDR_W(ADDR_W), .NUM_ACT(NUM_ACT)) u_dec (
    .addr     (reg_addr),
    .sel_mask (sel_mask),
    .sel_bp   (sel_bp),
    .sel_abp  (sel_abp),
    .sel_act  (sel_act)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  mask_q <= '0;
    else if (reg_wr && sel_mask) mask_q <= reg_wdata[MASK_W-1:0];
  end

  prio_cpuif_bp_bank #(.HAS_SEC(HAS_SEC), .MIN_BP(MIN_BP)) u_bp (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .ns       (reg_ns),
    .sel_bp   (sel_bp),
    .sel_abp  (sel_abp),
    .wval     (reg_wdata[BP_W-1:0]),
    .rd_bp    (rd_bp),
    .rd_abp   (rd_abp),
    .bp_sec_q (bp_sec_q),
    .bp_ns_q  (bp_ns_q)
  );

  prio_cpuif_act_words #(.DATA_W(DATA_W), .NUM_ACT(NUM_ACT)) u_act (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .sel_act (sel_act),
    .wdata   (reg_wdata),
    .rd_act  (rd_act)
  );

  always_comb begin
    reg_rdata = '0;
    if (sel_mask)     reg_rdata[MASK_W-1:0] = mask_q;
    if (sel_bp)       reg_rdata[BP_W-1:0]   = rd_bp;
    if (sel_abp)      reg_rdata[BP_W-1:0]   = rd_abp;
    if (|sel_act)     reg_rdata             = rd_act;
  end
endmodule

// File: rtl/prio_cpuif_regs_chk.sv
module prio_cpuif_regs_chk
  import prio_cpuif_pkg::*;
#(
  parameter bit          HAS_SEC = 1'b1,
  parameter int unsigned MIN_BP  = 2,
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 32,
  parameter int          NUM_ACT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_ns,
  input logic [MASK_W-1:0] wlow,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [MASK_W-1:0] mask_q,
  input bp_t               bp_sec_q,
  input bp_t               bp_ns_q
);
  logic a_mask, a_bp, a_abp, a_act, listed;
  assign a_mask = (reg_addr == ADDR_W'(OFF_MASK));
  assign a_bp   = (reg_addr == ADDR_W'(OFF_BP));
  assign a_abp  = (reg_addr == ADDR_W'(OFF_ABP));
  assign a_act  = (reg_addr >= ADDR_W'(OFF_ACT0)) &&
                  (reg_addr <= ADDR_W'(OFF_ACT0 + 4 * (NUM_ACT - 1))) &&
                  (reg_addr[1:0] == 2'b00);
  assign listed = a_mask || a_bp || a_abp || a_act;

  p_mask_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && a_mask) |=> (mask_q == $past(wlow)));

  p_sec_bp_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && a_bp && !(HAS_SEC && reg_ns)) |=> (bp_sec_q == $past(wlow[BP_W-1:0])));

  p_sec_kept_on_ns_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_SEC && reg_wr && reg_ns) |=> $stable(bp_sec_q));

  p_ns_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bp_ns_q >= bp_t'(MIN_BP));

  p_alias_hidden_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_abp && (reg_ns || !HAS_SEC)) |-> (reg_rdata == '0));

  p_alias_ns_wr_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && a_abp && reg_ns) |=> $stable(bp_ns_q));

  p_unlisted_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !listed |-> (reg_rdata == '0));
endmodule

bind prio_cpuif_regs prio_cpuif_regs_chk #(
  .HAS_SEC(HAS_SEC), .MIN_BP(MIN_BP), .ADDR_W(ADDR_W),
  .DATA_W(DATA_W), .NUM_ACT(NUM_ACT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_ns    (reg_ns),
  .wlow      (reg_wdata[7:0]),
  .reg_rdata (reg_rdata),
  .mask_q    (mask_q),
  .bp_sec_q  (bp_sec_q),
  .bp_ns_q   (bp_ns_q)
);

// File: tb/prio_cpuif_regs_test.sv
module prio_cpuif_regs_test;
  localparam int MINB = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_ns = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd_sec;
  logic [31:0] rd_flat;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // reference state, index 1 = security present, 0 = absent
  logic [7:0]  m_mask [2];
  logic [2:0]  m_sbp  [2];
  logic [2:0]  m_nbp  [2];
  logic [31:0] m_act  [2][4];

  always #5 clk = ~clk;

  prio_cpuif_regs #(.HAS_SEC(1'b1), .MIN_BP(MINB)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_ns(reg_ns), .reg_wdata(reg_wdata), .reg_rdata(rd_sec));

  prio_cpuif_regs #(.HAS_SEC(1'b0), .MIN_BP(MINB)) uut_flat (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_ns(reg_ns), .reg_wdata(reg_wdata), .reg_rdata(rd_flat));

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      report();
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%h ns=%0b got=%h exp=%h", tag, reg_addr, reg_ns, got, exp);
    end
  endtask

  function automatic logic [2:0] lift(input logic [2:0] v);
    return (v < 3'(MINB)) ? 3'(MINB) : v;
  endfunction

  function automatic logic [31:0] exp_rd(input int c, input logic [7:0] a, input logic ns);
    logic nsv = (c == 1) && ns;
    if (a == 8'h04) return {24'd0, m_mask[c]};
    if (a == 8'h08) return {29'd0, nsv ? m_nbp[c] : m_sbp[c]};
    if (a == 8'h1C) return (c == 1 && !ns) ? {29'd0, m_nbp[c]} : 32'd0;
    if (a >= 8'hD0 && a <= 8'hDC && a[1:0] == 2'b00) return m_act[c][(a - 8'hD0) >> 2];
    return 32'd0;
  endfunction

  function automatic string tag_of(input logic [7:0] a, input logic ns);
    if (a == 8'h04) return "R2";
    if (a == 8'h08) return ns ? "R4" : "R3";
    if (a == 8'h1C) return ns ? "R6" : "R7";
    if (a >= 8'hD0 && a <= 8'hDC && a[1:0] == 2'b00) return "R8";
    return "R9";
  endfunction

  task automatic model_wr(input logic [7:0] a, input logic [31:0] d, input logic ns);
    for (int c = 0; c < 2; c++) begin
      logic nsv = (c == 1) && ns;
      if (a == 8'h04) m_mask[c] = d[7:0];
      if (a == 8'h08) begin
        if (nsv) m_nbp[c] = lift(d[2:0]);
        else     m_sbp[c] = d[2:0];
      end
      if (a == 8'h1C && c == 1 && !ns) m_nbp[c] = lift(d[2:0]);
      if (a >= 8'hD0 && a <= 8'hDC && a[1:0] == 2'b00) m_act[c][(a - 8'hD0) >> 2] = d;
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d, input logic ns);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_ns = ns;
    @(negedge clk);
    reg_wr = 1'b0;
    model_wr(a, d, ns);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic ns, input string tag);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a; reg_ns = ns;
    #1;
    check(tag, rd_sec, exp_rd(1, a, ns));
    check("R10", rd_flat, exp_rd(0, a, ns));
  endtask

  task automatic rd_all(input string tag);
    logic [7:0] lst [7] = '{8'h04, 8'h08, 8'h1C, 8'hD0, 8'hD4, 8'hD8, 8'hDC};
    for (int i = 0; i < 7; i++) begin
      for (int n = 0; n < 2; n++) rd_chk(lst[i], n[0], tag);
    end
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_mask[c] = '0; m_sbp[c] = '0; m_nbp[c] = 3'(MINB);
      for (int k = 0; k < 4; k++) m_act[c][k] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values through every view
    rd_all("R1");

    // R11: write visible only after the sampling edge
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h04; reg_ns = 1'b0; reg_wdata = 32'h0000_005A;
    #1;
    check("R11", rd_sec, 32'd0);
    @(negedge clk);
    reg_wr = 1'b0;
    model_wr(8'h04, 32'h5A, 1'b0);
    #1;
    check("R11", rd_sec, 32'h5A);

    // R3 R4 R5 R7 R10: binary point sweep
    for (int v = 0; v < 8; v++) begin
      do_wr(8'h08, 32'hFFFF_FFF8 | 32'(v), 1'b0);
      rd_all("R3");
      do_wr(8'h08, 32'(7 - v), 1'b1);
      rd_all("R5");
      do_wr(8'h1C, 32'(v), 1'b0);
      rd_all("R7");
      do_wr(8'h1C, 32'(7 - v), 1'b1);
      rd_all("R7");
    end

    // R2: mask patterns
    for (int i = 0; i < 16; i++) begin
      do_wr(8'h04, 32'h00AB_CD00 + 32'(i * 37), i[0]);
      rd_chk(8'h04, 1'b0, "R2");
      rd_chk(8'h04, 1'b1, "R2");
    end

    // R8: active words, distinct patterns
    for (int k = 0; k < 4; k++) do_wr(8'(8'hD0 + 4 * k), 32'h1357_9BDF ^ (32'h1111_1111 * 32'(k + 1)), k[0]);
    rd_all("R8");

    // R9 and all offsets: full offset sweep, both security states
    for (int a = 0; a < 256; a++) begin
      for (int n = 0; n < 2; n++) begin
        do_wr(8'(a), 32'hFFFF_FFFF ^ 32'(a), n[0]);
        rd_chk(8'(a), n[0], tag_of(8'(a), n[0]));
        rd_all("R9");
      end
    end

    report();
  end
endmodule